// File: doc/BRIEF.md
# Remote Alarm Persistence Detector

This block filters the one-bit remote-failure indicator that upstream logic pulls out of each received E3 frame's maintenance byte. A frame strobe marks each cycle in which the indicator is valid. The block changes its declared alarm state only after the indicator has disagreed with that state for a run of back-to-back frames. The run length is selectable between a short run of 3 frames and a long run of 5 frames. The same length applies when the alarm is raised and when it is dropped.

Each change of the declared state, in either direction, sets an interrupt flag. Reading the interrupt register clears that flag. An enable bit decides whether the flag drives the interrupt pin. All of this is reached through a byte-wide register port with separate read and write strobes. Reads return data combinationally in the strobe cycle, and the read-clear takes effect at the clock edge that ends the strobe.

Top module: `rmt_alarm_persist`

## Requirements
- R1: Bit 4 of the register at address 0x10 is read/write and resets to 0. A value of 0 selects a run of 3 frames and a value of 1 selects a run of 5. The other bits of that register read 0.
- R2: While the alarm is clear, it becomes declared at the clock edge of the strobed frame that completes the selected run of consecutive frames with the indicator at 1.
- R3: While the alarm is declared, it becomes clear at the clock edge of the strobed frame that completes the selected run of consecutive frames with the indicator at 0.
- R4: Bit 0 of the read-only register at address 0x11 shows the declared state: 1 while declared, 0 after reset.
- R5: Every change of the declared state, declare or clear, sets bit 3 of the register at address 0x13. That bit is 0 after reset.
- R6: A read of address 0x13 clears bit 3 at the end of the read cycle. The read itself returns the value from before the clear.
- R7: A strobed frame whose indicator matches the declared state restarts the run, so the earlier disagreeing frames no longer count.
- R8: Cycles without a frame strobe leave the run count and the declared state unchanged, whatever the indicator input does.
- R9: A write that changes the run-length select restarts the run, and the new length counts from the next frame.
- R10: Bit 3 of the read/write register at address 0x12 enables the interrupt pin and resets to 0. The pin is 1 exactly when that enable and the interrupt flag are both 1. The enable never affects the flag.
- R11: If a state change and a read of address 0x13 fall in the same cycle, the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| frm_stb | input | 1 | Marks a cycle that carries a valid indicator bit for one received frame |
| rmt_ind | input | 1 | Remote-failure indicator bit of the current frame |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; a read of 0x13 clears the interrupt flag |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high, 0 otherwise |
| irq_o | output | 1 | Interrupt request: enabled interrupt flag |

## Verification
Two functions can land on the same clock edge: a frame that completes a run and so sets the interrupt flag, and a read of the interrupt register that clears it. The bench first clears the flag with a read. It then lines up the final frame of a clearing run with a read of address 0x13 in the same cycle. The value returned during that read must be 0. A read that follows must show bit 3 at 1, because a lost event would leave it at 0.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned SHORT_RUN = 3;
  localparam int unsigned LONG_RUN  = 5;
  localparam int unsigned CNT_W     = $clog2(LONG_RUN + 1);

  localparam logic [ADDR_W-1:0] CFG_ADDR = 8'h10;
  localparam logic [ADDR_W-1:0] STS_ADDR = 8'h11;
  localparam logic [ADDR_W-1:0] ENA_ADDR = 8'h12;
  localparam logic [ADDR_W-1:0] IRQ_ADDR = 8'h13;

  localparam int unsigned SEL_BIT = 4;
  localparam int unsigned STS_BIT = 0;
  localparam int unsigned IRQ_BIT = 3;

  typedef enum logic {
    ALM_CLEAR    = 1'b0,
    ALM_DECLARED = 1'b1
  } alm_state_e;
endpackage

// File: rtl/rmt_rst_sync.sv
module rmt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rmt_persist.sv
module rmt_persist
  import rmt_pkg::*;
#(
  parameter int unsigned SHORT_N = SHORT_RUN,
  parameter int unsigned LONG_N  = LONG_RUN,
  parameter int unsigned CW      = $clog2(LONG_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_stb,
  input  logic          ind,
  input  logic          sel_long,
  input  logic          restart,
  output logic          state_o,
  output logic          evt_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW:0] SHORT_LIM = CW'(SHORT_N);
  localparam logic [CW:0] LONG_LIM  = CW'(LONG_N);

  alm_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;
  logic [CW:0]   run_lim;
  logic [CW:0]   cnt_inc;

  assign run_lim = sel_long ? LONG_LIM : SHORT_LIM;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    evt_o  = 1'b0;
    upd_en = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      upd_en = 1'b1;
    end else if (frm_stb) begin
      upd_en = 1'b1;
      if (ind != st_q) begin
        if (cnt_inc >= run_lim) begin
          st_d  = (st_q == ALM_CLEAR) ? ALM_DECLARED : ALM_CLEAR;
          cnt_d = '0;
          evt_o = 1'b1;
        end else begin
          cnt_d = cnt_inc[CW-1:0];
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  // state registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ALM_CLEAR;
      cnt_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rmt_regs.sv
module rmt_regs
  import rmt_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic          alm_state,
  input  logic          irq_flag,
  output logic [DW-1:0] rdata,
  output logic          sel_long,
  output logic          irq_en,
  output logic          sel_restart,
  output logic          irq_rd_clr
);
  localparam logic [DW-1:0] CFG_MASK = DW'(1) << SEL_BIT;
  localparam logic [DW-1:0] ENA_MASK = DW'(1) << IRQ_BIT;

  logic [DW-1:0] cfg_q, cfg_d;
  logic [DW-1:0] ena_q, ena_d;
  logic          cfg_we, ena_we;
  logic [DW-1:0] sts_vec, irq_vec;

  assign cfg_we = wr && (addr == CFG_ADDR);
  assign ena_we = wr && (addr == ENA_ADDR);
  assign cfg_d  = wdata & CFG_MASK;
  assign ena_d  = wdata & ENA_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= '0;
    else if (ena_we) ena_q <= ena_d;
  end

  assign sel_long    = cfg_q[SEL_BIT];
  assign irq_en      = ena_q[IRQ_BIT];
  assign sel_restart = cfg_we && (cfg_d[SEL_BIT] != cfg_q[SEL_BIT]);
  assign irq_rd_clr  = rd && (addr == IRQ_ADDR);

  always_comb begin
    sts_vec          = '0;
    sts_vec[STS_BIT] = alm_state;
    irq_vec          = '0;
    irq_vec[IRQ_BIT] = irq_flag;
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        CFG_ADDR: rdata = cfg_q;
        STS_ADDR: rdata = sts_vec;
        ENA_ADDR: rdata = ena_q;
        IRQ_ADDR: rdata = irq_vec;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rmt_irq.sv
module rmt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd_clr,
  input  logic en,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d, flag_we;

  // a new event outranks a read-clear in the same cycle
  always_comb begin
    flag_we = evt || rd_clr;
    flag_d  = evt ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_we) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en;
endmodule

// File: rtl/rmt_alarm_persist.sv
module rmt_alarm_persist
  import rmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_stb,
  input  logic              rmt_ind,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic             rst_s_n;
  logic             sel_long, irq_en, sel_restart, irq_rd_clr;
  logic             alm_state, alm_evt, irq_flag;
  logic [CNT_W-1:0] run_cnt;

  rmt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  rmt_persist #(.SHORT_N(SHORT_RUN), .LONG_N(LONG_RUN), .CW(CNT_W)) u_persist (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .frm_stb  (frm_stb),
    .ind      (rmt_ind),
    .sel_long (sel_long),
    .restart  (sel_restart),
    .state_o  (alm_state),
    .evt_o    (alm_evt),
    .cnt_o    (run_cnt)
  );

  rmt_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .addr        (reg_addr),
    .wr          (reg_wr),
    .wdata       (reg_wdata),
    .rd          (reg_rd),
    .alm_state   (alm_state),
    .irq_flag    (irq_flag),
    .rdata       (reg_rdata),
    .sel_long    (sel_long),
    .irq_en      (irq_en),
    .sel_restart (sel_restart),
    .irq_rd_clr  (irq_rd_clr)
  );

  rmt_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .evt    (alm_evt),
    .rd_clr (irq_rd_clr),
    .en     (irq_en),
    .flag_o (irq_flag),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/rmt_alarm_chk.sv
module rmt_alarm_chk
  import rmt_pkg::*;
(
  input logic              clk,
  input logic              rst_s_n,
  input logic              frm_stb,
  input logic              rmt_ind,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              alm_state,
  input logic              alm_evt,
  input logic              irq_flag,
  input logic              sel_long,
  input logic              sel_restart,
  input logic [CNT_W-1:0]  run_cnt
);
  logic rd_irq;
  assign rd_irq = reg_rd && (reg_addr == IRQ_ADDR);

  // R8: no strobe, no state or count movement
  p_hold_no_stb_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!frm_stb && !sel_restart) |=> ($stable(alm_state) && $stable(run_cnt)));

  // R5: any state change leaves the flag set
  p_flag_on_change_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    alm_evt |=> (irq_flag && (alm_state != $past(alm_state))));

  // R6: read-clear with no competing event drops the flag
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_irq && !alm_evt) |=> !irq_flag);

  // R11: event wins over simultaneous read-clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_irq && alm_evt) |=> irq_flag);

  // R7: an agreeing frame restarts the run
  p_agree_restart_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (frm_stb && !sel_restart && (rmt_ind == alm_state)) |=> (run_cnt == '0));

  // R9: select change restarts the run
  p_sel_restart_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    sel_restart |=> (run_cnt == '0));

  // R2/R3: count stays below the active run length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    sel_long ? (run_cnt < CNT_W'(LONG_RUN)) : (run_cnt < CNT_W'(SHORT_RUN)));
endmodule

bind rmt_alarm_persist rmt_alarm_chk u_chk (
  .clk         (clk),
  .rst_s_n     (rst_s_n),
  .frm_stb     (frm_stb),
  .rmt_ind     (rmt_ind),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .alm_state   (alm_state),
  .alm_evt     (alm_evt),
  .irq_flag    (irq_flag),
  .sel_long    (sel_long),
  .sel_restart (sel_restart),
  .run_cnt     (run_cnt)
);

// File: tb/tb_rmt_alarm_persist.sv
module tb_rmt_alarm_persist;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_stb = 1'b0;
  logic       rmt_ind = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rmt_alarm_persist dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_stb   (frm_stb),
    .rmt_ind   (rmt_ind),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  // {indicator, expected status after frame}; short run of 3
  localparam int NVEC = 17;
  localparam logic [1:0] VEC [NVEC] = '{
    2'b10, 2'b10, 2'b11, 2'b01, 2'b01, 2'b11, 2'b01, 2'b01, 2'b00,
    2'b10, 2'b00, 2'b10, 2'b10, 2'b11, 2'b01, 2'b01, 2'b00
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic b);
    @(negedge clk);
    frm_stb = 1'b1;
    rmt_ind = b;
    @(negedge clk);
    frm_stb = 1'b0;
    rmt_ind = ~b;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1;
    reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state: R1 R4 R5 R10
    rd(8'h10, v); check("R1 cfg reset", v, 8'h00);
    rd(8'h11, v); check("R4 status reset", v, 8'h00);
    rd(8'h13, v); check("R5 flag reset", v, 8'h00);
    rd(8'h12, v); check("R10 enable reset", v, 8'h00);
    check("R10 irq reset", {7'd0, irq_o}, 8'h00);

    // table walk, short run: R2 R3 R7
    for (int i = 0; i < NVEC; i++) begin
      frame(VEC[i][1]);
      rd(8'h11, v);
      check($sformatf("R2/R3/R7 vec %0d", i), v, {7'd0, VEC[i][0]});
    end

    // R5 set by transitions, R6 read-clear
    rd(8'h13, v); check("R5 flag after transitions", v, 8'h08);
    rd(8'h13, v); check("R6 flag cleared by read", v, 8'h00);

    // R10: disabled pin, flag still set
    frame(1'b1); frame(1'b1); frame(1'b1);
    rd(8'h11, v); check("R2 declare", v, 8'h01);
    check("R10 pin masked", {7'd0, irq_o}, 8'h00);
    rd(8'h13, v); check("R10 flag independent", v, 8'h08);
    wr(8'h12, 8'hFF);
    rd(8'h12, v); check("R10 enable readback", v, 8'h08);
    frame(1'b0); frame(1'b0); frame(1'b0);
    @(negedge clk);
    check("R10 pin asserted", {7'd0, irq_o}, 8'h01);
    rd(8'h13, v); check("R6 read returns old", v, 8'h08);
    #1 check("R10 pin drops after clear", {7'd0, irq_o}, 8'h00);

    // R1: long run
    wr(8'h10, 8'hFF);
    rd(8'h10, v); check("R1 cfg readback", v, 8'h10);
    for (int i = 0; i < 4; i++) frame(1'b1);
    rd(8'h11, v); check("R2 long run not yet", v, 8'h00);
    frame(1'b1);
    rd(8'h11, v); check("R2 long run declare", v, 8'h01);
    for (int i = 0; i < 4; i++) frame(1'b0);
    rd(8'h11, v); check("R3 long run not yet", v, 8'h01);
    frame(1'b0);
    rd(8'h11, v); check("R3 long run clear", v, 8'h00);

    // R9: select change restarts run
    for (int i = 0; i < 4; i++) frame(1'b1);
    wr(8'h10, 8'h00);
    frame(1'b1); frame(1'b1);
    rd(8'h11, v); check("R9 run restarted", v, 8'h00);
    frame(1'b1);
    rd(8'h11, v); check("R9 new length applies", v, 8'h01);

    // R8: no strobe, indicator at 0 for many cycles
    @(negedge clk);
    rmt_ind = 1'b0;
    repeat (10) @(negedge clk);
    rd(8'h11, v); check("R8 no strobe hold", v, 8'h01);
    frame(1'b0); frame(1'b0);
    rmt_ind = 1'b0;
    repeat (6) @(negedge clk);
    rd(8'h11, v); check("R8 count held", v, 8'h01);

    // R11: event and read-clear in the same cycle
    rd(8'h13, v);
    @(negedge clk);
    frm_stb = 1'b1;
    rmt_ind = 1'b0;
    reg_rd = 1'b1;
    reg_addr = 8'h13;
    #1 v = reg_rdata;
    check("R11 read before event", v, 8'h00);
    @(negedge clk);
    frm_stb = 1'b0;
    reg_rd = 1'b0;
    rd(8'h11, v); check("R3 cleared at collision", v, 8'h00);
    rd(8'h13, v); check("R11 flag survives read", v, 8'h08);

    finish_run();
  end
endmodule